// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Controller

This block scans a small multiplexed segment display. Software writes a mode register, three bytes of segment-disable bits and a display RAM that holds one bit per pixel, with one row for each common phase. Once enabled, the block makes its own frame timing. It picks a count source, which is either a slow-oscillator tick or the system clock. It prescales and divides that source, then steps through 2, 3 or 4 common phases. On each phase it reads the matching RAM row and drives every common and segment output with a 2-bit level code. The code stands for a bias voltage; the analog ladder and the pad drivers sit outside the block.

A per-pin multiplexer decides whether each of the 24 segment pins carries the display drive or general port data. That decision follows the pin's direction bit, its disable bit (with inverted sense on the upper eight pins) and a power-tap select input. The power-tap select claims the top two pins for another use.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: Register writes (wr_en high for one cycle) decode `wr_addr` as follows. Address 0 is the mode register. Addresses 1, 2 and 3 hold disable bits for segments 0-7, 8-15 and 16-23. Address 0x10 | row<<2 | byte writes display RAM, where byte 0..2 covers segments byte*8 to byte*8+7 and a 1 bit turns the pixel on. Mode bits: [0] enable, [1] source (1 = system clock), [3:2] duty code, [5:4] divider code, [6] half bias, [7] timing type B.
- R2: While scanning, the phase advances 0,1,..,last,0 and so on. Duty code 01 uses commons 0-1, code 10 uses commons 0-2 and code 11 uses commons 0-3.
- R3: The phase steps every MAIN_DIV*2^div system clocks when the source bit is 1. When the source bit is 0, it steps every SLOW_DIV*2^div slow ticks.
- R4: Exactly one active common shows the select code: 3 under polarity 0, 0 under polarity 1. The other active commons show 1 (polarity 0) or 2 (polarity 1).
- R5: A segment owned by the display shows 0 for an on pixel under polarity 0 and 3 under polarity 1. For an off pixel it shows 2 under polarity 0 and 1 under polarity 1.
- R6: With half bias set, code 2 replaces every non-select common code and every off-pixel segment code.
- R7: Type A inverts the polarity on every phase step. Type B inverts it only when the phase wraps to 0.
- R8: With enable 0, with duty code 00, or in reset, all common and segment codes are 0. Scanning restarts at phase 0 with polarity 0.
- R9: Segments 0-15 are owned by the display when their disable bit is 0 and their direction bit is 1.
- R10: Segments 16-23 are owned by the display when their disable bit is 1 and their direction bit is 1.
- R11: A pin whose direction bit is 0 is never owned by the display. `pin_port` equals `port_out & port_dir` on pins not owned by the display and 0 on owned pins. A segment pin that is not owned shows code 0.
- R12: While `tap_sel` is 1, segments 22 and 23 are never owned by the display, whatever their disable bits are.
- R13: Commons above the active duty show code 0 while scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle pulse per slow-oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register / RAM write address |
| wr_data | input | 8 | Write data |
| port_dir | input | 24 | Direction bit per pin, 1 = output |
| port_out | input | 24 | Port data per pin |
| tap_sel | input | 1 | Power-tap select, reserves pins 22-23 |
| com_lvl | output | 8 | Level code per common, 2 bits each, common k at [2k+1:2k] |
| seg_lvl | output | 48 | Level code per segment, 2 bits each |
| pin_lcd | output | 24 | 1 = pin carries display drive |
| pin_port | output | 24 | Port data driven on pins not owned by the display |

## Verification
The phase counter, the polarity flag and the RAM row read all show up in the common and segment codes within two clocks. A phase that skips or runs past the duty shows up at the next step as a wrong select common or a wrong row on the segments. A wrong polarity toggle shows up as an inverted select code at the first step. A prescaler or divider that miscounts appears as a wrong number of clocks between steps, which can be measured at the ports. A wrong ownership term shows up one clock after the register or input changes, on `pin_lcd`, `pin_port` and the segment codes together.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_OFF = 2'd0;

  function automatic lvl_t com_select(input logic pol);
    return pol ? 2'd0 : 2'd3;
  endfunction

  function automatic lvl_t com_idle(input logic pol, input logic half);
    if (half) return 2'd2;
    return pol ? 2'd2 : 2'd1;
  endfunction

  function automatic lvl_t seg_on(input logic pol);
    return pol ? 2'd3 : 2'd0;
  endfunction

  function automatic lvl_t seg_off(input logic pol, input logic half);
    if (half) return 2'd2;
    return pol ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/lcd_tick_gen.sv
module lcd_tick_gen #(
  parameter int MAIN_DIV = 8192,
  parameter int SLOW_DIV = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       src_main,
  input  logic       slow_tick,
  input  logic [1:0] div_code,
  output logic       step
);
  localparam int MAXD = (MAIN_DIV > SLOW_DIV) ? MAIN_DIV : SLOW_DIV;
  localparam int CW   = $clog2(MAXD);

  logic [CW-1:0] pcnt;
  logic [2:0]    dcnt;
  logic          src_tick, pre_tick;
  logic [CW-1:0] lim;
  logic [2:0]    dlim;

  assign src_tick = src_main | slow_tick;
  assign lim      = src_main ? CW'(MAIN_DIV - 1) : CW'(SLOW_DIV - 1);
  assign pre_tick = (src_main ? 1'b1 : slow_tick) && (pcnt >= lim);
  assign dlim     = (3'd1 << div_code) - 3'd1;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      dcnt <= '0;
      step <= 1'b0;
    end else begin
      step <= 1'b0;
      if (src_main || src_tick) begin
        if ((src_main || slow_tick) && pre_tick) pcnt <= '0;
        else if (src_main || slow_tick)          pcnt <= pcnt + 1'b1;
      end
      if (pre_tick) begin
        if (dcnt >= dlim) begin
          dcnt <= '0;
          step <= 1'b1;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end

  // R3
  step_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq #(
  parameter int NCOM = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    step,
  input  logic [1:0]              duty,
  input  logic                    type_b,
  output logic [$clog2(NCOM)-1:0] phase,
  output logic                    pol
);
  localparam int PH_W = $clog2(NCOM);

  logic [1:0] duty_q;
  logic       last;

  assign last = (phase >= PH_W'(duty));

  always_ff @(posedge clk) begin
    if (rst) duty_q <= '0;
    else     duty_q <= duty;
  end

  always_ff @(posedge clk) begin
    if (rst || !run || (duty != duty_q)) begin
      phase <= '0;
      pol   <= 1'b0;
    end else if (step) begin
      if (last) begin
        phase <= '0;
        pol   <= ~pol;
      end else begin
        phase <= phase + 1'b1;
        if (!type_b) pol <= ~pol;
      end
    end
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $stable(duty)) |-> (phase <= PH_W'(duty)));

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !step) |=> ($stable(phase) || !run || !$stable(duty)));

  // R7
  type_a_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (run && step && !type_b && $stable(duty)) |=> ((pol != $past(pol)) || !run || !$stable(duty)));
endmodule

// File: rtl/lcd_pin_mux.sv
module lcd_pin_mux #(
  parameter int NSEG     = 24,
  parameter int INV_FROM = 16,
  parameter int TAP_LO   = 22
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEG-1:0] dis,
  input  logic [NSEG-1:0] dir,
  input  logic [NSEG-1:0] port_out,
  input  logic            tap_sel,
  output logic [NSEG-1:0] owned,
  output logic [NSEG-1:0] pin_lcd,
  output logic [NSEG-1:0] pin_port
);
  for (genvar i = 0; i < NSEG; i++) begin : g_pin
    logic want;
    if (i >= INV_FROM) begin : g_inv
      assign want = dis[i];
    end else begin : g_norm
      assign want = ~dis[i];
    end
    if (i >= TAP_LO) begin : g_tap
      assign owned[i] = dir[i] & want & ~tap_sel;
    end else begin : g_plain
      assign owned[i] = dir[i] & want;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_lcd  <= '0;
      pin_port <= '0;
    end else begin
      pin_lcd  <= owned;
      pin_port <= port_out & dir & ~owned;
    end
  end

  // R12
  tap_reserve_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tap_sel) |-> (pin_lcd[NSEG-1:TAP_LO] == '0));

  // R11
  dir_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((~$past(dir)) & pin_lcd) == '0);
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NSEG     = 24,
  parameter int NCOM     = 4,
  parameter int MAIN_DIV = 8192,
  parameter int SLOW_DIV = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_tick,
  input  logic              wr_en,
  input  logic [5:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NSEG-1:0]   port_dir,
  input  logic [NSEG-1:0]   port_out,
  input  logic              tap_sel,
  output logic [2*NCOM-1:0] com_lvl,
  output logic [2*NSEG-1:0] seg_lvl,
  output logic [NSEG-1:0]   pin_lcd,
  output logic [NSEG-1:0]   pin_port
);
  localparam int NBYTE = NSEG / 8;
  localparam int PH_W  = $clog2(NCOM);

  logic [7:0]      mode_q;
  logic [NSEG-1:0] dis_q;
  logic            en, src_main, half, type_b, run, step, pol;
  logic [1:0]      duty, div_code;
  logic [PH_W-1:0] phase;
  logic            ram_we;
  logic [NSEG-1:0] row_q;
  logic [NSEG-1:0] owned;
  logic            s1_run, s1_pol;
  logic [PH_W-1:0] s1_phase;

  assign en       = mode_q[0];
  assign src_main = mode_q[1];
  assign duty     = mode_q[3:2];
  assign div_code = mode_q[5:4];
  assign half     = mode_q[6];
  assign type_b   = mode_q[7];
  assign run      = en && (duty != 2'd0);
  assign ram_we   = wr_en && (wr_addr[5:4] == 2'b01);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      dis_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == 6'd0) mode_q <= wr_data;
      for (int b = 0; b < NBYTE; b++)
        if (wr_addr == 6'(b + 1)) dis_q[b*8 +: 8] <= wr_data;
    end
  end

  lcd_tick_gen #(.MAIN_DIV(MAIN_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(run), .src_main(src_main),
    .slow_tick(slow_tick), .div_code(div_code), .step(step)
  );

  lcd_phase_seq #(.NCOM(NCOM)) u_seq (
    .clk(clk), .rst(rst), .run(run), .step(step), .duty(duty),
    .type_b(type_b), .phase(phase), .pol(pol)
  );

  lcd_pin_mux #(.NSEG(NSEG), .INV_FROM(16), .TAP_LO(NSEG - 2)) u_mux (
    .clk(clk), .rst(rst), .dis(dis_q), .dir(port_dir),
    .port_out(port_out), .tap_sel(tap_sel), .owned(owned),
    .pin_lcd(pin_lcd), .pin_port(pin_port)
  );

  // Display RAM: one narrow memory per segment byte, synchronous read
  for (genvar b = 0; b < NBYTE; b++) begin : g_ram
    logic [7:0] mem [NCOM];
    always_ff @(posedge clk) begin
      if (ram_we && (wr_addr[1:0] == 2'(b)))
        mem[wr_addr[2 +: PH_W]] <= wr_data;
      row_q[b*8 +: 8] <= mem[phase];
    end
  end

  // Stage 1: align phase and polarity with the RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_run   <= 1'b0;
      s1_pol   <= 1'b0;
      s1_phase <= '0;
    end else begin
      s1_run   <= run;
      s1_pol   <= pol;
      s1_phase <= phase;
    end
  end

  // Stage 2: registered level codes
  for (genvar k = 0; k < NCOM; k++) begin : g_com
    always_ff @(posedge clk) begin
      if (rst || !s1_run)                  com_lvl[2*k +: 2] <= LVL_OFF;
      else if (s1_phase == PH_W'(k))       com_lvl[2*k +: 2] <= com_select(s1_pol);
      else if (3'(k) <= {1'b0, duty})      com_lvl[2*k +: 2] <= com_idle(s1_pol, half);
      else                                 com_lvl[2*k +: 2] <= LVL_OFF;
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst || !s1_run || !owned[i]) seg_lvl[2*i +: 2] <= LVL_OFF;
      else if (row_q[i])               seg_lvl[2*i +: 2] <= seg_on(s1_pol);
      else                             seg_lvl[2*i +: 2] <= seg_off(s1_pol, half);
    end
  end

  // R8
  off_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(run, 2) |-> ((com_lvl == '0) && (seg_lvl == '0)));
endmodule

// File: tb/tb_lcd_scan_ctrl.sv
module tb_lcd_scan_ctrl;
  localparam int NSEG = 24;
  localparam int NCOM = 4;
  localparam int MD   = 8;
  localparam int SD   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slow_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NSEG-1:0] port_dir = '1;
  logic [NSEG-1:0] port_out = '0;
  logic tap_sel = 1'b0;
  logic [2*NCOM-1:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;
  logic [NSEG-1:0] pin_lcd, pin_port;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] ram_exp [NCOM][3];
  logic [NSEG-1:0] dis_b = '0;

  lcd_scan_ctrl #(.NSEG(NSEG), .NCOM(NCOM), .MAIN_DIV(MD), .SLOW_DIV(SD)) dut (
    .clk(clk), .rst(rst), .slow_tick(slow_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .port_dir(port_dir),
    .port_out(port_out), .tap_sel(tap_sel), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .pin_lcd(pin_lcd), .pin_port(pin_port)
  );

  always #10 clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      slow_tick = (c % 3 == 0);
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic bit own_exp(input int i);
    bit w;
    w = (i >= 16) ? dis_b[i] : ~dis_b[i];
    if (tap_sel && i >= 22) w = 1'b0;
    return port_dir[i] & w;
  endfunction

  function automatic logic [1:0] e_com(input int k, input int p, input bit pol, input int n, input bit half);
    if (k == p) return pol ? 2'd0 : 2'd3;
    if (k < n)  return half ? 2'd2 : (pol ? 2'd2 : 2'd1);
    return 2'd0;
  endfunction

  function automatic logic [1:0] e_seg(input int i, input int p, input bit pol, input bit half);
    if (!own_exp(i)) return 2'd0;
    if (ram_exp[p][i/8][i%8]) return pol ? 2'd3 : 2'd0;
    return half ? 2'd2 : (pol ? 2'd1 : 2'd2);
  endfunction

  task automatic set_dis(input logic [NSEG-1:0] v);
    dis_b = v;
    wr(6'd1, v[7:0]);
    wr(6'd2, v[15:8]);
    wr(6'd3, v[23:16]);
  endtask

  task automatic chk_off(input string req);
    repeat (4) @(negedge clk);
    check((com_lvl == '0) && (seg_lvl == '0), req, {8'h0, com_lvl, seg_lvl}, 64'h0);
  endtask

  task automatic chk_mux();
    logic [NSEG-1:0] eo, ep;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NSEG; i++) eo[i] = own_exp(i);
    ep = port_out & port_dir & ~eo;
    check(pin_lcd[15:0] == eo[15:0], "R9", 64'(pin_lcd[15:0]), 64'(eo[15:0]));
    check(pin_lcd[21:16] == eo[21:16], "R10", 64'(pin_lcd[21:16]), 64'(eo[21:16]));
    check(pin_lcd[23:22] == eo[23:22], "R12", 64'(pin_lcd[23:22]), 64'(eo[23:22]));
    check(pin_port == ep, "R11", 64'(pin_port), 64'(ep));
  endtask

  task automatic run_scan(input int n, input bit half, input bit tb, input int dv, input bit src, input int nsteps);
    int prev_p, cyc, last_chg, steps, period;
    bit prev_pol, first;
    wr(6'd0, {tb, half, 2'(dv), 2'(n - 1), src, 1'b1});
    repeat (3) @(negedge clk);
    period = src ? (MD << dv) : (3 * SD) << dv;
    prev_p = -1; prev_pol = 1'b0; cyc = 0; last_chg = -1; steps = 0; first = 1'b1;
    while (steps < nsteps && cyc < 4000) begin
      int nsel, p;
      bit pol;
      logic [7:0] ec;
      logic [47:0] es;
      @(negedge clk);
      cyc++;
      nsel = 0; p = 0;
      for (int k = 0; k < n; k++)
        if (com_lvl[2*k +: 2] == 2'd0 || com_lvl[2*k +: 2] == 2'd3) begin nsel++; p = k; end
      check(nsel == 1, "R4", 64'(com_lvl), 64'(nsel));
      if (nsel != 1) continue;
      pol = (com_lvl[2*p +: 2] == 2'd0);
      if (first) begin
        check(p == 0 && !pol, "R8", 64'(p), 64'(0));
        first = 1'b0;
      end
      for (int k = 0; k < NCOM; k++) ec[2*k +: 2] = e_com(k, p, pol, n, half);
      for (int i = 0; i < NSEG; i++) es[2*i +: 2] = e_seg(i, p, pol, half);
      // R13 commons above duty, R6 half bias codes
      check(com_lvl == ec, half ? "R6" : "R4", 64'(com_lvl), 64'(ec));
      // R1 RAM rows, R5 segment codes, R11 non-owned pins
      check(seg_lvl == es, half ? "R6" : "R5", 64'(seg_lvl), 64'(es));
      if (prev_p >= 0 && p != prev_p) begin
        check(p == (prev_p + 1) % n, "R2", 64'(p), 64'((prev_p + 1) % n));
        if (tb) check(pol == (prev_pol ^ (p == 0)), "R7", 64'(pol), 64'(prev_pol ^ (p == 0)));
        else    check(pol != prev_pol, "R7", 64'(pol), 64'(!prev_pol));
        if (last_chg >= 0) check(cyc - last_chg == period, "R3", 64'(cyc - last_chg), 64'(period));
        last_chg = cyc;
        steps++;
      end else if (prev_p >= 0) begin
        check(pol == prev_pol, "R7", 64'(pol), 64'(prev_pol));
      end
      prev_p = p; prev_pol = pol;
    end
    check(steps >= nsteps, "R3", 64'(steps), 64'(nsteps));
    wr(6'd0, 8'h00);
    chk_off("R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check((com_lvl == '0) && (seg_lvl == '0) && (pin_lcd == '0) && (pin_port == '0),
          "R8", {8'h0, com_lvl, seg_lvl}, 64'h0);
    rst = 1'b0;
    for (int r = 0; r < NCOM; r++)
      for (int b = 0; b < 3; b++) begin
        ram_exp[r][b] = 8'((r * 37 + b * 91 + 5) ^ (r << 5));
        wr(6'h10 | 6'(r << 2) | 6'(b), ram_exp[r][b]);
      end

    // Ownership sweeps
    port_dir = '1; port_out = 24'hA5C33C; tap_sel = 1'b0;
    set_dis(24'h000000); chk_mux();
    set_dis(24'hFFFFFF); chk_mux();
    tap_sel = 1'b1; chk_mux();
    set_dis(24'hF00F0F); port_dir = 24'hDFF7FE; chk_mux();
    tap_sel = 1'b0; chk_mux();
    port_dir = 24'h3C0F0F; port_out = 24'hFFFFFF; chk_mux();
    port_dir = '0; chk_mux();

    // Scan sweeps on the system-clock source
    port_dir = 24'hFFEFFF; port_out = 24'h123456;
    set_dis(24'hF00F00);
    for (int n = 2; n <= 4; n++)
      for (int h = 0; h < 2; h++)
        for (int t = 0; t < 2; t++)
          for (int dv = 0; dv < 4; dv += 3) begin
            tap_sel = (n == 3);
            run_scan(n, h[0], t[0], dv, 1'b1, 2 * n + 2);
          end

    // Slow-tick source
    set_dis(24'hC000F0); tap_sel = 1'b0;
    run_scan(4, 1'b0, 1'b1, 1, 1'b0, 10);
    run_scan(3, 1'b1, 1'b0, 0, 1'b0, 8);
    chk_mux();

    // Duty code 00 halts with enable set
    wr(6'd0, 8'h03);
    chk_off("R8");
    repeat (100) @(negedge clk);
    check((com_lvl == '0) && (seg_lvl == '0), "R8", {8'h0, com_lvl, seg_lvl}, 64'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule